// File: doc/BRIEF.md
# Shift-and-Add Radix-2 FFT Butterfly

This block is the arithmetic core of a 64-point decimation-in-frequency FFT. On each accepted cycle it takes two complex samples A and B and a 5-bit twiddle index k. It returns the halved sum of the two samples. It also returns their halved difference, rotated by the twiddle factor W = e^(-j2πk/64). Halving at every butterfly keeps a six-stage transform from growing past the word width. The surrounding sequencer supplies operand pairs and indices in whatever order its memory schedule needs. The block keeps no state between butterflies.

The rotation uses no general multiplier. Each coefficient magnitude needed inside one octant of the unit circle is a fixed network of shifts and adds or subtracts, written in canonical signed-digit form. One group of networks holds cosine-side constants and the other holds sine-side constants. The networks run on both halves of the difference. Their products are then picked by the reduced index. Indices past the first quarter turn are handled by a swap and negate of the difference, which multiplies it by -j. Indices past an octant are handled by exchanging the two constant groups. The trivial indices 0 and 16 use a pure shift and a zero, so they lose nothing to coefficient rounding.

Each packed 32-bit operand is two's complement Q1.15: real part in bits 31:16, imaginary part in bits 15:0. The block is pipelined with two register stages and accepts one butterfly per cycle.

Top module: `r2_butterfly_shiftadd`

## Requirements
- R1: `out_sum` holds, for each component, (a + b + 1) >> 1. Here `>>` is an arithmetic shift (floor), a and b are the signed 16-bit parts, the real part is in bits 31:16 and the imaginary part is in bits 15:0.
- R2: With k = 0, each component of `out_diff` equals d = (a - b + 1) >> 1, clamped to the 16-bit range. For example, a - b = 1 gives 1 and a - b = -1 gives 0.
- R3: For any k from 0 to 31, let C = round(32768·cos(2πk/64)) and S = round(32768·sin(2πk/64)). Then the real part of `out_diff` is clamp((dr·C + di·S) >> 15) and the imaginary part is clamp((di·C - dr·S) >> 15). Here dr and di are the halved differences of R2, and the shift is applied once, after the final addition.
- R4: With k = 16, `out_diff` equals (clamp(di), -dr) exactly: a quarter turn with no coefficient error.
- R5: Any rotated or halved difference component above 32767 or below -32768 is replaced by 32767 or -32768 respectively.
- R6: `out_valid` is `in_valid` delayed by exactly two clock cycles. The matching result appears on the same cycle, and back-to-back inputs produce back-to-back results.
- R7: While `rst` (synchronous, active high) is asserted, `out_valid`, `out_sum` and `out_diff` are all zero, whatever `in_valid` is.
- R8: On a cycle where `out_valid` is low, `out_sum` and `out_diff` keep the values of the last result, or zero if there has been none since reset. Data presented without `in_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_a, in_b and in_k this cycle |
| in_a | input | 32 | Sample A, real in 31:16, imaginary in 15:0, Q1.15 |
| in_b | input | 32 | Sample B, same packing |
| in_k | input | 5 | Twiddle index 0..31 |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_sum | output | 32 | Halved sum (A + B) / 2 |
| out_diff | output | 32 | Halved difference rotated by W^k |

## Verification
The bench builds the block with its default 16-bit component width and the fixed 15 fraction bits. With these values full-scale operands can push the rotated components past ±1, so the clamp is reached, and the ±1 differences probe the round-half-up rule at the smallest step. Every index from 0 to 31 is swept on one fixed operand pair, which covers both constant groups, the mirrored octants and the quarter-turn swap. Random gaps in `in_valid` test the two-cycle alignment and show that the output registers hold their values.

// File: rtl/r2_butterfly_shiftadd.sv
`timescale 1ns/1ps
module r2_butterfly_shiftadd #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2*DW-1:0] in_a,
  input  logic [2*DW-1:0] in_b,
  input  logic [4:0]      in_k,
  output logic            out_valid,
  output logic [2*DW-1:0] out_sum,
  output logic [2*DW-1:0] out_diff
);
  localparam int CF  = 15;
  localparam int EW  = DW + 1;
  localparam int TW  = DW + 2;
  localparam int CW  = CF + 2;
  localparam int PW  = EW + CW + 1;
  localparam int AW  = PW + 1;
  localparam int RW  = AW - CF;
  localparam int OCT = 8;

  function automatic int coef(input int m);
    case (m)
      0:  return 32768;
      1:  return 32610;
      2:  return 32138;
      3:  return 31357;
      4:  return 30274;
      5:  return 28899;
      6:  return 27246;
      7:  return 25330;
      8:  return 23170;
      9:  return 20788;
      10: return 18205;
      11: return 15447;
      12: return 12540;
      13: return 9512;
      14: return 6393;
      15: return 3212;
      default: return 0;
    endcase
  endfunction

  function automatic logic signed [TW-1:0] ext(input logic [DW-1:0] x);
    return {{2{x[DW-1]}}, x};
  endfunction

  function automatic logic signed [EW-1:0] halve(input logic signed [TW-1:0] t);
    logic signed [TW-1:0] u;
    u = t + TW'(1);
    return u[TW-1:1];
  endfunction

  function automatic logic signed [PW-1:0] csd_mul(input logic signed [EW-1:0] x, input int c);
    logic signed [PW-1:0] acc, xe;
    int rem;
    acc = '0;
    xe  = {{(PW-EW){x[EW-1]}}, x};
    rem = c;
    for (int i = 0; i < CW + 1; i++) begin
      if (rem[0]) begin
        if (rem[1]) begin
          acc = acc - (xe <<< i);
          rem = rem + 1;
        end else begin
          acc = acc + (xe <<< i);
          rem = rem - 1;
        end
      end
      rem = rem >>> 1;
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] clamp(input logic signed [AW-1:0] t);
    logic signed [RW-1:0] sh;
    sh = RW'(t >>> CF);
    if (&sh[RW-1:DW-1] || ~|sh[RW-1:DW-1]) return sh[DW-1:0];
    return sh[RW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  endfunction

  logic signed [EW-1:0] sr_c, si_c, dr_c, di_c, q_re, q_im;
  assign sr_c = halve(ext(in_a[2*DW-1:DW]) + ext(in_b[2*DW-1:DW]));
  assign si_c = halve(ext(in_a[DW-1:0])    + ext(in_b[DW-1:0]));
  assign dr_c = halve(ext(in_a[2*DW-1:DW]) - ext(in_b[2*DW-1:DW]));
  assign di_c = halve(ext(in_a[DW-1:0])    - ext(in_b[DW-1:0]));
  assign q_re = in_k[4] ? di_c  : dr_c;
  assign q_im = in_k[4] ? -dr_c : di_c;

  logic                 v1;
  logic [2*DW-1:0]      s1_sum;
  logic signed [EW-1:0] s1_re, s1_im;
  logic [3:0]           s1_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      s1_sum <= '0;
      s1_re  <= '0;
      s1_im  <= '0;
      s1_r   <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        s1_sum <= {sr_c[DW-1:0], si_c[DW-1:0]};
        s1_re  <= q_re;
        s1_im  <= q_im;
        s1_r   <= in_k[3:0];
      end
    end
  end

  logic       mirror;
  logic [3:0] oct;
  assign mirror = s1_r > 4'd8;
  assign oct    = mirror ? 4'd0 - s1_r : s1_r;

  logic signed [PW-1:0] re_cos [OCT+1];
  logic signed [PW-1:0] re_sin [OCT+1];
  logic signed [PW-1:0] im_cos [OCT+1];
  logic signed [PW-1:0] im_sin [OCT+1];

  for (genvar g = 0; g <= OCT; g++) begin : g_net
    localparam int CA = coef(g);
    localparam int CB = coef(2*OCT - g);
    assign re_cos[g] = csd_mul(s1_re, CA);
    assign re_sin[g] = csd_mul(s1_re, CB);
    assign im_cos[g] = csd_mul(s1_im, CA);
    assign im_sin[g] = csd_mul(s1_im, CB);
  end

  logic signed [PW-1:0] p_rc, p_rs, p_ic, p_is;
  assign p_rc = mirror ? re_sin[oct] : re_cos[oct];
  assign p_rs = mirror ? re_cos[oct] : re_sin[oct];
  assign p_ic = mirror ? im_sin[oct] : im_cos[oct];
  assign p_is = mirror ? im_cos[oct] : im_sin[oct];

  logic signed [AW-1:0] acc_re, acc_im;
  assign acc_re = AW'(p_rc) + AW'(p_is);
  assign acc_im = AW'(p_ic) - AW'(p_rs);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_diff  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_sum  <= s1_sum;
        out_diff <= {clamp(acc_re), clamp(acc_im)};
      end
    end
  end
endmodule

// File: rtl/r2_butterfly_shiftadd_chk.sv
`timescale 1ns/1ps
module r2_butterfly_shiftadd_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2*DW-1:0] in_a,
  input logic [2*DW-1:0] in_b,
  input logic [4:0]      in_k,
  input logic            out_valid,
  input logic [2*DW-1:0] out_sum,
  input logic [2*DW-1:0] out_diff
);
  function automatic logic signed [DW:0] hv(input logic [DW-1:0] x, input logic [DW-1:0] y, input bit sub);
    logic signed [DW+1:0] t, xe, ye;
    xe = {{2{x[DW-1]}}, x};
    ye = {{2{y[DW-1]}}, y};
    t  = sub ? xe - ye : xe + ye;
    t  = t + (DW+2)'(1);
    return t[DW+1:1];
  endfunction

  function automatic logic [DW-1:0] lim(input logic signed [DW:0] v);
    if (v[DW] != v[DW-1]) return v[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return v[DW-1:0];
  endfunction

  function automatic logic [2*DW-1:0] sum_pk(input logic [2*DW-1:0] a, input logic [2*DW-1:0] b);
    return {lim(hv(a[2*DW-1:DW], b[2*DW-1:DW], 1'b0)), lim(hv(a[DW-1:0], b[DW-1:0], 1'b0))};
  endfunction

  function automatic logic [2*DW-1:0] d0_pk(input logic [2*DW-1:0] a, input logic [2*DW-1:0] b);
    return {lim(hv(a[2*DW-1:DW], b[2*DW-1:DW], 1'b1)), lim(hv(a[DW-1:0], b[DW-1:0], 1'b1))};
  endfunction

  function automatic logic [2*DW-1:0] d16_pk(input logic [2*DW-1:0] a, input logic [2*DW-1:0] b);
    logic signed [DW:0] n;
    n = -hv(a[2*DW-1:DW], b[2*DW-1:DW], 1'b1);
    return {lim(hv(a[DW-1:0], b[DW-1:0], 1'b1)), lim(n)};
  endfunction

  a_r1_sum: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sum == sum_pk($past(in_a, 2), $past(in_b, 2)));

  a_r2_k0_diff: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_k, 2) == 5'd0) |-> out_diff == d0_pk($past(in_a, 2), $past(in_b, 2)));

  a_r4_quarter_turn: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_k, 2) == 5'd16) |-> out_diff == d16_pk($past(in_a, 2), $past(in_b, 2)));

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_sum) && $stable(out_diff)));
endmodule

bind r2_butterfly_shiftadd r2_butterfly_shiftadd_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_k(in_k),
  .out_valid(out_valid), .out_sum(out_sum), .out_diff(out_diff)
);

// File: tb/tb_r2_butterfly_shiftadd.sv
`timescale 1ns/1ps
module tb_r2_butterfly_shiftadd;
  localparam int DW = 16;
  localparam int W2 = 2 * DW;
  localparam real PI = 3.14159265358979323846;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W2-1:0] in_a = '0;
  logic [W2-1:0] in_b = '0;
  logic [4:0]    in_k = '0;
  logic          out_valid;
  logic [W2-1:0] out_sum, out_diff;

  always #5 clk = ~clk;

  r2_butterfly_shiftadd #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_k(in_k),
    .out_valid(out_valid), .out_sum(out_sum), .out_diff(out_diff)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint cc[32];
  longint ss[32];

  bit            m0_v = 1'b0, m1_v = 1'b0;
  logic [W2-1:0] m0_s = '0, m0_d = '0, m1_s = '0, m1_d = '0;
  logic [W2-1:0] last_s = '0, last_d = '0;
  string         m0_t = "", m1_t = "";

  function automatic longint sx(input logic [DW-1:0] x);
    return longint'($signed(x));
  endfunction

  function automatic longint hf(input longint t);
    return (t + 1) >>> 1;
  endfunction

  function automatic longint clampv(input longint t);
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return t;
  endfunction

  function automatic logic [W2-1:0] pk(input longint re, input longint im);
    logic [DW-1:0] r, i;
    r = re[DW-1:0];
    i = im[DW-1:0];
    return {r, i};
  endfunction

  task automatic chk(input string tag, input logic [W2-1:0] act, input logic [W2-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [W2-1:0] a, input logic [W2-1:0] b, input logic [4:0] k);
    longint dr, di, re, im, cre, cim;
    @(negedge clk);
    if (m1_v) begin
      last_s = m1_s;
      last_d = m1_d;
    end
    chk("R6 out_valid", W2'(out_valid), W2'(m1_v));
    chk(m1_v ? "R1 sum" : "R8 hold sum", out_sum, last_s);
    chk(m1_v ? m1_t : "R8 hold diff", out_diff, last_d);
    dr  = hf(sx(a[W2-1:DW]) - sx(b[W2-1:DW]));
    di  = hf(sx(a[DW-1:0]) - sx(b[DW-1:0]));
    re  = (dr * cc[k] + di * ss[k]) >>> 15;
    im  = (di * cc[k] - dr * ss[k]) >>> 15;
    cre = clampv(re);
    cim = clampv(im);
    m1_v = m0_v; m1_s = m0_s; m1_d = m0_d; m1_t = m0_t;
    m0_v = v;
    m0_s = pk(hf(sx(a[W2-1:DW]) + sx(b[W2-1:DW])), hf(sx(a[DW-1:0]) + sx(b[DW-1:0])));
    m0_d = pk(cre, cim);
    if (cre != re || cim != im) m0_t = "R5 saturated diff";
    else if (k == 5'd0)         m0_t = "R2 diff k=0";
    else if (k == 5'd16)        m0_t = "R4 diff k=16";
    else                        m0_t = "R3 rotated diff";
    in_valid = v;
    in_a = a;
    in_b = b;
    in_k = k;
  endtask

  function automatic logic [DW-1:0] pick(input int sel);
    case (sel)
      0: return 16'h7fff;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'h0001;
      4: return 16'hffff;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the end of the run");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 32; k++) begin
      cc[k] = longint'($floor(32768.0 * $cos(2.0 * PI * k / 64.0) + 0.5));
      ss[k] = longint'($floor(32768.0 * $sin(2.0 * PI * k / 64.0) + 0.5));
    end

    // R7: reset clears outputs even with in_valid high
    rst = 1'b1;
    in_valid = 1'b1;
    in_a = 32'h12345678;
    in_b = 32'h0badf00d;
    in_k = 5'd3;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 reset out_valid", W2'(out_valid), '0);
      chk("R7 reset out_sum", out_sum, '0);
      chk("R7 reset out_diff", out_diff, '0);
    end
    rst = 1'b0;
    in_valid = 1'b0;

    // R2 rounding of +1 and -1 differences
    step(1'b1, pk(1, -1), pk(0, 0), 5'd0);
    step(1'b1, pk(0, 3), pk(1, 0), 5'd0);
    step(1'b1, pk(-3, 2), pk(0, 5), 5'd0);
    // R5 clamp at k=0 and R4 quarter turn at full scale
    step(1'b1, pk(32767, 32767), pk(-32768, -32768), 5'd0);
    step(1'b1, pk(32767, 32767), pk(-32768, -32768), 5'd16);
    step(1'b1, pk(-32768, 32767), pk(32767, -32768), 5'd16);
    step(1'b1, pk(-32768, -32768), pk(-32768, -32768), 5'd8);
    // R5 rotation past full scale at 45 degrees
    step(1'b1, pk(32767, -32768), pk(-32768, 32767), 5'd8);
    step(1'b1, pk(32767, 32767), pk(-32768, -32768), 5'd24);
    // R3 sweep of every index back to back
    for (int k = 0; k < 32; k++) step(1'b1, pk(20000, -12000), pk(-9000, 7000), 5'(k));
    // R8 idle data has no effect
    for (int i = 0; i < 5; i++) step(1'b0, W2'($urandom), W2'($urandom), 5'($urandom));

    for (int n = 0; n < 6000; n++) begin
      logic [W2-1:0] a, b;
      bit v;
      v = ($urandom % 4) != 0;
      if (n % 8 == 0) begin
        a = {pick($urandom % 6), pick($urandom % 6)};
        b = {pick($urandom % 6), pick($urandom % 6)};
      end else begin
        a = W2'($urandom);
        b = W2'($urandom);
      end
      step(v, a, b, 5'($urandom));
    end
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule